// File: doc/BRIEF.md
# Configuration EEPROM Shadow Loader

This block keeps a copy of a 64-word, 16-bit configuration EEPROM in on-chip registers and answers indexed word lookups from that copy. It does not drive the EEPROM pins. Each word transfer goes through a request port on a serial master, one word at a time. The master pulses `mst_done` when a transfer finishes. With a read it also returns the data, and with a write it also returns a timeout flag.

The shadow is valid only when word 0 carries a signature pattern: (word 0 AND `SIG_MASK`) equals `SIG_PAT`. Loading works as follows:

- All 64 words are read in ascending order and summed modulo 2^16.
- A sum other than `SUM_TARGET` clears shadow word 0 to 0x0000.
- A good sum with a signature that does not match is reported as a signature failure.

A lookup against an invalid shadow first forces a full reload. A write through the block clears shadow word 0, so the next lookup reloads. The checksum-update command recomputes word 63 so that the image sums to the target.

Commands are single-cycle pulses that are sampled only while `busy` is low. The states are:

- `S_IDLE`: waiting for a command.
- `S_LD_RD`: reading the 64 words.
- `S_LD_CHK`: judging sum and signature.
- `S_LK_RSP`: one-cycle lookup answer.
- `S_WR_GO`: single word write.
- `S_UP_RD`: summing words 0..62.
- `S_UP_WR`: writing the new checksum word.

The transitions are:

- From `S_IDLE`:
  - A lookup goes to `S_LK_RSP` when the index is 64 or more, or when the signature is valid.
  - Any other lookup goes to `S_LD_RD`.
  - A write goes to `S_WR_GO`.
  - An update goes to `S_UP_RD`.
  - A load goes to `S_LD_RD`.
- `S_LD_RD` moves to `S_LD_CHK` when the read of word 63 completes.
- `S_LD_CHK` moves to `S_LK_RSP` if the load was started by a lookup, otherwise to `S_IDLE`.
- `S_UP_RD` moves to `S_UP_WR` when the read of word 62 completes.
- `S_WR_GO` and `S_UP_WR` move to `S_IDLE` on `mst_done`.
- `S_LK_RSP` always moves to `S_IDLE`.

Top module: `eesh_loader`

## Requirements
- R1: After reset the block is idle: `busy`, `mst_req`, `lk_done` and all status flags are low, and the shadow is invalid, so the first in-range lookup triggers a reload.
- R2: A load issues reads of words 0,1,...,63 in strictly ascending order, one outstanding request at a time, and `loading` is high throughout.
- R3: If the 16-bit wrapping sum of the 64 loaded words is not 0xBABA, `cksum_bad` is set, shadow word 0 becomes 0x0000, and in-range lookups return 0.
- R4: If the sum is good but (word0 & 0xC000) != 0x4000, `sig_bad` is set and in-range lookups return 0.
- R5: A lookup with index below 64 on a valid shadow completes with no master traffic. `lk_done` is high for exactly one cycle, and `lk_data` carries the stored word.
- R6: A lookup with index below 64 on an invalid shadow runs a full reload first. It returns the word if the shadow is then valid, and 0 otherwise.
- R7: A lookup with index 64 or greater returns 0 with no master traffic.
- R8: A write command issues exactly one master write of the given word and clears shadow word 0, so the next lookup reloads.
- R9: The checksum update reads words 0..62 and writes (0xBABA - sum) mod 2^16 to word 63. It also clears shadow word 0.
- R10: `wr_tmo` holds the timeout result of the most recent write (command or checksum write) and is cleared when the next one is accepted.
- R11: Commands are sampled only while `busy` is low, in the priority lookup > write > update > load. Lower-priority requests in the same cycle are ignored.
- R12: The load command refreshes the shadow, after which lookups are served without master traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup command pulse |
| lk_idx | input | 7 | Lookup word index (values of 64 and up are out of range) |
| wr_req | input | 1 | Word write command pulse |
| wr_idx | input | 6 | Word address to write |
| wr_data | input | 16 | Data to write |
| upd_req | input | 1 | Checksum update command pulse |
| load_req | input | 1 | Explicit reload command pulse |
| busy | output | 1 | A command is in progress |
| lk_done | output | 1 | Lookup result valid, one cycle |
| lk_data | output | 16 | Lookup result |
| loading | output | 1 | Reload in progress |
| cksum_bad | output | 1 | Last load failed the checksum |
| sig_bad | output | 1 | Last load failed the signature |
| wr_tmo | output | 1 | Last write timed out |
| mst_req | output | 1 | Transfer request to the serial master |
| mst_we | output | 1 | Transfer is a write |
| mst_addr | output | 6 | Transfer word address |
| mst_wdata | output | 16 | Transfer write data |
| mst_done | input | 1 | Transfer complete pulse from the master |
| mst_rdata | input | 16 | Read data, valid with `mst_done` |
| mst_tmo | input | 1 | Write timed out, valid with `mst_done` |

## Verification
The bench targets these failure modes:

- **Stale shadow after a write.** A design that fails to invalidate would answer the lookup from the old copy without any master reads.
- **Checksum failure leaves word 0 intact.** A design that skips the clear would go on returning data from a corrupt image.
- **Wrong update arithmetic.** An off-by-one range in the update sum, or a reversed subtraction, shows up as a wrong word 63 in the model memory.
- **Out-of-range indices.** A design that truncates the index would alias 64 onto word 0.
- **Simultaneous commands.** A design with the wrong priority would perform a write or reload instead of the lookup.
- **Write timeout.** A timed-out write must leave the memory unchanged and raise the flag until the next write.

// File: rtl/eesh_pkg.sv
package eesh_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LD_RD,
        S_LD_CHK,
        S_LK_RSP,
        S_WR_GO,
        S_UP_RD,
        S_UP_WR
    } eesh_state_e;
endpackage

// File: rtl/eesh_sum.sv
module eesh_sum #(
    parameter int              DW     = 16,
    parameter logic [DW-1:0]   TARGET = 16'hBABA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] sum,
    output logic          hit
);
    logic [DW-1:0] acc_q;

    // Wrapping accumulator: width DW drops the carry out naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (clr)   acc_q <= '0;
        else if (add)   acc_q <= acc_q + word;
    end

    assign sum = acc_q;
    assign hit = (acc_q == TARGET);
endmodule

// File: rtl/eesh_store.sv
module eesh_store #(
    parameter int WORDS = 64,
    parameter int DW    = 16,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] word0
);
    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n)
                mem_q[i] <= '0;
            else if (we && waddr == i[AW-1:0])
                mem_q[i] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
    assign word0 = mem_q[0];
endmodule

// File: rtl/eesh_loader.sv
module eesh_loader
    import eesh_pkg::*;
#(
    parameter int            WORDS      = 64,
    parameter int            DW         = 16,
    parameter logic [DW-1:0] SIG_MASK   = 16'hC000,
    parameter logic [DW-1:0] SIG_PAT    = 16'h4000,
    parameter logic [DW-1:0] SUM_TARGET = 16'hBABA,
    localparam int           AW         = $clog2(WORDS),
    localparam int           IW         = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lk_req,
    input  logic [IW-1:0] lk_idx,
    input  logic          wr_req,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          upd_req,
    input  logic          load_req,
    output logic          busy,
    output logic          lk_done,
    output logic [DW-1:0] lk_data,
    output logic          loading,
    output logic          cksum_bad,
    output logic          sig_bad,
    output logic          wr_tmo,
    output logic          mst_req,
    output logic          mst_we,
    output logic [AW-1:0] mst_addr,
    output logic [DW-1:0] mst_wdata,
    input  logic          mst_done,
    input  logic [DW-1:0] mst_rdata,
    input  logic          mst_tmo
);
    localparam logic [AW-1:0] LAST    = AW'(WORDS - 1);
    localparam logic [AW-1:0] LAST_RD = AW'(WORDS - 2);
    localparam logic [IW-1:0] LIMIT   = IW'(WORDS);

    eesh_state_e   state_q, state_d;
    logic [AW-1:0] ptr_q, addr_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] wdata_q;
    logic          ret_q, ck_bad_q, sig_bad_q, tmo_q;

    logic [DW-1:0] sh_rdata, sh_word0, sum;
    logic          sum_hit, sh_we;
    logic [AW-1:0] sh_waddr;
    logic [DW-1:0] sh_wdata;

    logic idle, sig_ok, lk_hit;
    logic acc_lk, acc_wr, acc_up, acc_ld;
    logic start_load, start_scan, scan_step;

    assign idle   = (state_q == S_IDLE);
    assign sig_ok = ((sh_word0 & SIG_MASK) == SIG_PAT);
    assign lk_hit = (lk_idx >= LIMIT) || sig_ok;

    // Fixed priority among commands sampled in the idle state.
    assign acc_lk = idle && lk_req;
    assign acc_wr = idle && !lk_req && wr_req;
    assign acc_up = idle && !lk_req && !wr_req && upd_req;
    assign acc_ld = idle && !lk_req && !wr_req && !upd_req && load_req;

    assign start_load = acc_ld || (acc_lk && !lk_hit);
    assign start_scan = start_load || acc_up;
    assign scan_step  = mst_done && (state_q == S_LD_RD || state_q == S_UP_RD);

    eesh_store #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sh_we),
        .waddr (sh_waddr),
        .wdata (sh_wdata),
        .raddr (idx_q[AW-1:0]),
        .rdata (sh_rdata),
        .word0 (sh_word0)
    );

    eesh_sum #(.DW(DW), .TARGET(SUM_TARGET)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_scan),
        .add   (scan_step),
        .word  (mst_rdata),
        .sum   (sum),
        .hit   (sum_hit)
    );

    // Shadow write port: loaded words, or clearing word 0 to invalidate.
    always_comb begin
        sh_we    = 1'b0;
        sh_waddr = '0;
        sh_wdata = '0;
        if (state_q == S_LD_RD && mst_done) begin
            sh_we    = 1'b1;
            sh_waddr = ptr_q;
            sh_wdata = mst_rdata;
        end else if ((state_q == S_LD_CHK && !sum_hit) || acc_wr || acc_up) begin
            sh_we    = 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (acc_lk)      state_d = lk_hit ? S_LK_RSP : S_LD_RD;
                else if (acc_wr) state_d = S_WR_GO;
                else if (acc_up) state_d = S_UP_RD;
                else if (acc_ld) state_d = S_LD_RD;
            end
            S_LD_RD:  if (mst_done && ptr_q == LAST) state_d = S_LD_CHK;
            S_LD_CHK: state_d = ret_q ? S_LK_RSP : S_IDLE;
            S_LK_RSP: state_d = S_IDLE;
            S_WR_GO:  if (mst_done) state_d = S_IDLE;
            S_UP_RD:  if (mst_done && ptr_q == LAST_RD) state_d = S_UP_WR;
            S_UP_WR:  if (mst_done) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            idx_q     <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            ret_q     <= 1'b0;
            ck_bad_q  <= 1'b0;
            sig_bad_q <= 1'b0;
            tmo_q     <= 1'b0;
        end else begin
            if (acc_lk) begin
                idx_q <= lk_idx;
                ret_q <= 1'b1;
            end
            if (acc_ld) ret_q <= 1'b0;
            if (start_scan) ptr_q <= '0;
            else if (scan_step) ptr_q <= ptr_q + 1'b1;
            if (start_load) begin
                ck_bad_q  <= 1'b0;
                sig_bad_q <= 1'b0;
            end
            if (acc_wr) begin
                addr_q  <= wr_idx;
                wdata_q <= wr_data;
            end
            if (acc_wr || acc_up) tmo_q <= 1'b0;
            if (state_q == S_LD_CHK) begin
                if (!sum_hit)     ck_bad_q  <= 1'b1;
                else if (!sig_ok) sig_bad_q <= 1'b1;
            end
            if ((state_q == S_WR_GO || state_q == S_UP_WR) && mst_done)
                tmo_q <= mst_tmo;
        end
    end

    always_comb begin
        busy      = !idle;
        loading   = (state_q == S_LD_RD) || (state_q == S_LD_CHK);
        lk_done   = (state_q == S_LK_RSP);
        lk_data   = (lk_done && idx_q < LIMIT && sig_ok) ? sh_rdata : '0;
        cksum_bad = ck_bad_q;
        sig_bad   = sig_bad_q;
        wr_tmo    = tmo_q;
        mst_req   = (state_q == S_LD_RD) || (state_q == S_UP_RD) ||
                    (state_q == S_WR_GO) || (state_q == S_UP_WR);
        mst_we    = (state_q == S_WR_GO) || (state_q == S_UP_WR);
        if (state_q == S_UP_WR)      mst_addr = LAST;
        else if (state_q == S_WR_GO) mst_addr = addr_q;
        else                         mst_addr = ptr_q;
        mst_wdata = (state_q == S_UP_WR) ? (SUM_TARGET - sum) : wdata_q;
    end
endmodule

// File: rtl/eesh_loader_chk.sv
module eesh_loader_chk #(
    parameter int WORDS = 64,
    parameter int DW    = 16,
    parameter int AW    = $clog2(WORDS),
    parameter int IW    = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lk_req,
    input logic [IW-1:0] lk_idx,
    input logic          busy,
    input logic          lk_done,
    input logic [DW-1:0] lk_data,
    input logic          loading,
    input logic          cksum_bad,
    input logic          sig_bad,
    input logic          mst_req,
    input logic          mst_we,
    input logic [AW-1:0] mst_addr,
    input logic          mst_done
);
    logic [IW-1:0] seen_idx;

    always_ff @(posedge clk) begin
        if (!rst_n)                seen_idx <= '0;
        else if (lk_req && !busy)  seen_idx <= lk_idx;
    end

    // R2: each load read moves to the next address
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && mst_req && mst_done && mst_addr != AW'(WORDS - 1))
        |=> (mst_addr == $past(mst_addr) + 1'b1));

    // R2: a pending request keeps its address until the master finishes
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && !mst_done) |=> (mst_req && $stable(mst_addr) && $stable(mst_we)));

    // R2: load traffic is reads only
    a_r2_load_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && mst_req) |-> !mst_we);

    // R3: checksum and signature failures are exclusive
    a_r3_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cksum_bad && sig_bad));

    // R5: lookup result lasts one cycle and happens while busy
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> (busy && !mst_req) ##1 !lk_done);

    // R6: nonzero lookup data never follows a failed load
    a_r6_no_data_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_data != '0) |-> (!cksum_bad && !sig_bad));

    // R7: out-of-range index returns zero
    a_r7_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && seen_idx >= IW'(WORDS)) |-> (lk_data == '0));
endmodule

bind eesh_loader eesh_loader_chk #(.WORDS(WORDS), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_idx    (lk_idx),
    .busy      (busy),
    .lk_done   (lk_done),
    .lk_data   (lk_data),
    .loading   (loading),
    .cksum_bad (cksum_bad),
    .sig_bad   (sig_bad),
    .mst_req   (mst_req),
    .mst_we    (mst_we),
    .mst_addr  (mst_addr),
    .mst_done  (mst_done)
);

// File: tb/eesh_loader_test.sv
module eesh_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0, wr_req = 1'b0, upd_req = 1'b0, load_req = 1'b0;
    logic [6:0]  lk_idx = '0;
    logic [5:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        busy, lk_done, loading, cksum_bad, sig_bad, wr_tmo;
    logic [15:0] lk_data;
    logic        mst_req, mst_we;
    logic [5:0]  mst_addr;
    logic [15:0] mst_wdata;
    logic        mst_done, mst_tmo;
    logic [15:0] mst_rdata;

    // Bench controls for the master model
    logic tmo_mode = 1'b0;
    logic mclr = 1'b0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    eesh_loader uut (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_idx(lk_idx),
        .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data),
        .upd_req(upd_req), .load_req(load_req),
        .busy(busy), .lk_done(lk_done), .lk_data(lk_data),
        .loading(loading), .cksum_bad(cksum_bad), .sig_bad(sig_bad), .wr_tmo(wr_tmo),
        .mst_req(mst_req), .mst_we(mst_we), .mst_addr(mst_addr), .mst_wdata(mst_wdata),
        .mst_done(mst_done), .mst_rdata(mst_rdata), .mst_tmo(mst_tmo)
    );

    // Serial master model with a 64-word memory
    logic [15:0] mem [64];
    int          m_cnt, rd_count, wr_count;
    logic [5:0]  m_addr, nxt;
    logic        m_we, seq_err, saw_load;
    logic [15:0] m_wd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; mst_done <= 1'b0; mst_tmo <= 1'b0; mst_rdata <= '0;
            rd_count <= 0; wr_count <= 0; nxt <= '0; seq_err <= 1'b0; saw_load <= 1'b0;
            m_addr <= '0; m_we <= 1'b0; m_wd <= '0;
        end else begin
            mst_done <= 1'b0;
            if (mclr) begin
                rd_count <= 0; wr_count <= 0; nxt <= '0; seq_err <= 1'b0; saw_load <= 1'b0;
            end
            if (loading) saw_load <= 1'b1;
            if (m_cnt != 0) begin
                m_cnt <= m_cnt - 1;
                if (m_cnt == 1) begin
                    mst_done <= 1'b1;
                    if (m_we) begin
                        mst_tmo  <= tmo_mode;
                        if (!tmo_mode) mem[m_addr] <= m_wd;
                        wr_count <= wr_count + 1;
                    end else begin
                        mst_tmo   <= 1'b0;
                        mst_rdata <= mem[m_addr];
                    end
                end
            end else if (mst_req && !mst_done) begin
                m_cnt  <= 3;
                m_addr <= mst_addr;
                m_we   <= mst_we;
                m_wd   <= mst_wdata;
                if (!mst_we) begin
                    rd_count <= rd_count + 1;
                    if (mst_addr != nxt) seq_err <= 1'b1;
                    nxt <= mst_addr + 1'b1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic lk, input logic wr, input logic up, input logic ld,
                         input logic [6:0] idx, input logic [5:0] widx, input logic [15:0] wd);
        @(negedge clk);
        while (busy) @(negedge clk);
        lk_req = lk; wr_req = wr; upd_req = up; load_req = ld;
        lk_idx = idx; wr_idx = widx; wr_data = wd; mclr = 1'b1;
        @(negedge clk);
        lk_req = 1'b0; wr_req = 1'b0; upd_req = 1'b0; load_req = 1'b0; mclr = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic lookup(input logic [6:0] idx, output logic [15:0] data);
        issue(1'b1, 1'b0, 1'b0, 1'b0, idx, '0, '0);
        while (!lk_done) @(negedge clk);
        data = lk_data;
        @(negedge clk);
        wait_idle();
    endtask

    task automatic write_word(input logic [5:0] a, input logic [15:0] d);
        issue(1'b0, 1'b1, 1'b0, 1'b0, '0, a, d);
        wait_idle();
    endtask

    task automatic update_sum();
        issue(1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0);
        wait_idle();
    endtask

    function automatic logic [15:0] sum63();
        logic [15:0] s = '0;
        for (int i = 0; i < 63; i++) s = s + mem[i];
        return s;
    endfunction

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 mst_req", mst_req, 0);
        chk("R1 lk_done", lk_done, 0);
        chk("R1 flags", {cksum_bad, sig_bad, wr_tmo}, 0);
    endtask

    task automatic t_first_lookup();
        logic [15:0] d;
        lookup(7'd5, d);
        chk("R6 R1 first lookup data", d, mem[5]);
        chk("R2 read count", rd_count, 64);
        chk("R2 order", seq_err, 0);
        chk("R2 loading seen", saw_load, 1);
        chk("R3 cksum ok", cksum_bad, 0);
    endtask

    task automatic t_cached();
        logic [15:0] d;
        lookup(7'd63, d);
        chk("R5 cached data", d, mem[63]);
        chk("R5 no traffic", rd_count, 0);
    endtask

    task automatic t_oob();
        logic [15:0] d;
        lookup(7'd64, d);
        chk("R7 idx64 zero", d, 0);
        chk("R7 idx64 no traffic", rd_count, 0);
        lookup(7'd127, d);
        chk("R7 idx127 zero", d, 0);
    endtask

    task automatic t_write_invalidates();
        logic [15:0] d;
        write_word(6'd10, 16'h1234);
        chk("R8 memory written", mem[10], 16'h1234);
        chk("R8 one write", wr_count, 1);
        lookup(7'd10, d);
        chk("R8 reload forced", rd_count, 64);
        chk("R3 bad sum returns zero", d, 0);
        chk("R3 cksum_bad", cksum_bad, 1);
        chk("R3 sig_bad low", sig_bad, 0);
    endtask

    task automatic t_update();
        logic [15:0] d, exp;
        exp = 16'hBABA - sum63();
        update_sum();
        chk("R9 reads 0..62", rd_count, 63);
        chk("R9 word63", mem[63], exp);
        lookup(7'd10, d);
        chk("R9 reload after update", rd_count, 64);
        chk("R6 data after fix", d, 16'h1234);
        chk("R3 cksum cleared", cksum_bad, 0);
    endtask

    task automatic t_badsig();
        logic [15:0] d;
        write_word(6'd0, 16'h8000);
        update_sum();
        lookup(7'd3, d);
        chk("R4 bad signature zero", d, 0);
        chk("R4 sig_bad", sig_bad, 1);
        chk("R4 cksum ok", cksum_bad, 0);
    endtask

    task automatic t_explicit_load();
        logic [15:0] d;
        write_word(6'd0, 16'h4001);
        update_sum();
        issue(1'b0, 1'b0, 1'b0, 1'b1, '0, '0, '0);
        wait_idle();
        chk("R12 load reads", rd_count, 64);
        chk("R12 loading seen", saw_load, 1);
        chk("R12 flags clear", {cksum_bad, sig_bad}, 0);
        lookup(7'd3, d);
        chk("R12 served from shadow", rd_count, 0);
        chk("R12 data", d, mem[3]);
    endtask

    task automatic t_timeout();
        logic [15:0] old;
        old = mem[20];
        tmo_mode = 1'b1;
        write_word(6'd20, 16'hFFFF);
        chk("R10 tmo set", wr_tmo, 1);
        chk("R10 memory unchanged", mem[20], old);
        tmo_mode = 1'b0;
        write_word(6'd20, old);
        chk("R10 tmo cleared", wr_tmo, 0);
    endtask

    task automatic t_priority();
        logic [15:0] d, old;
        lookup(7'd2, d);
        chk("R6 revalidate", d, mem[2]);
        old = mem[2];
        issue(1'b1, 1'b1, 1'b1, 1'b1, 7'd2, 6'd2, 16'hDEAD);
        while (!lk_done) @(negedge clk);
        d = lk_data;
        @(negedge clk);
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R11 lookup won", d, old);
        chk("R11 write ignored", wr_count, 0);
        chk("R11 no reads", rd_count, 0);
        chk("R11 memory unchanged", mem[2], old);
        chk("R11 idle", busy, 0);
    endtask

    initial begin
        logic [15:0] s = '0;
        for (int i = 0; i < 63; i++) begin
            logic [15:0] v;
            v = (i == 0) ? 16'h4A5A : (16'(i * 16'h0713) ^ 16'h5C3A);
            mem[i] <= v;
            s = s + v;
        end
        mem[63] <= 16'hBABA - s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_lookup();
        t_cached();
        t_oob();
        t_write_invalidates();
        t_update();
        t_badsig();
        t_explicit_load();
        t_timeout();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R1 watchdog actual=hung expected=complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule